// File: doc/BRIEF.md
# VME64 Slave Bus Bridge

This block is the slave side of a VME64 card. It turns the asynchronous strobe handshake of the backplane into single-cycle read and write strobes on a plain synchronous bus, clocked by the system clock. The address strobe and the two data strobes pass through multi-flop synchronizers. The address, address modifier, write line, LWORD and write data are captured from the pins once the synchronized strobes show that a cycle has started.

The card takes its base address from the slot number on the geographic address pins, so it needs no jumpers. A card with no usable slot number answers any A32 cycle with a bus error instead of serving it. This covers a card that sees slot 0 (an older backplane with no geographic pins), slot 1 (the system controller position) or a failed parity check on the pins. Only aligned 32-bit single and block cycles are served. A block transfer ends with a bus error rather than cross an aligned 256-byte boundary. Two LED outputs stretch the single-cycle activity strobes so that they can be seen.

Top module: `vme_slave_bridge`

## Requirements
- R1: After reset, DTACK and BERR are negated (high), the DTACK driver enable and the data driver enable are low, and neither bus_rd nor bus_wr is asserted.
- R2: The slot number is the bitwise inverse of the five active-low geographic pins. A cycle is served only when address bits [31:16] equal the slot number (bits [31:21] zero), so slot 17 answers at 0x0011xxxx. A served write gives one bus_wr pulse with bus_addr equal to the VME address and bus_wdata equal to the VME data, followed by DTACK low.
- R3: A served read gives one bus_rd pulse. The bus_rdata value present on the cycle after that pulse appears on vme_d_out, and vme_d_oe is high while DTACK is low.
- R4: With slot 0, slot 1 or a parity failure, any cycle with an A32 address modifier (0x08, 0x09, 0x0B, 0x0C, 0x0D, 0x0F) gets BERR low, with no bus strobe.
- R5: The geographic pins pass the parity check when the six raw pin levels (five address pins plus the parity pin) hold an odd number of ones.
- R6: A cycle to the card's window with address bits [1:0] not 00, with LWORD high, or with only one data strobe asserted gets BERR, with no bus strobe.
- R7: Modifiers 0x09 and 0x0D are single cycles and 0x0B and 0x0F are block transfers. The 64-bit block modifiers 0x08 and 0x0C get BERR when they address the card. Any other modifier gets no response at all.
- R8: A cycle whose address lies outside the card's 64 KB window gets no DTACK, no BERR and no bus strobe.
- R9: In a block transfer, each beat after the first issues its strobe at the previous beat's address plus 4.
- R10: A block-transfer beat whose address would fall in the next aligned 256-byte block gets BERR and issues no strobe.
- R11: DTACK stays low until both data strobes are seen negated. The DTACK driver enable is high whenever DTACK is low, and also for the one cycle after DTACK returns high.
- R12: led_access goes high for LED_HOLD cycles after each bus strobe, starting on the cycle after it. led_rw does the same for bus_wr only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vme_as_n | input | 1 | Address strobe, active low |
| vme_ds_n | input | 2 | Data strobes, active low |
| vme_write_n | input | 1 | Low for a write cycle |
| vme_lword_n | input | 1 | Low for a longword transfer |
| vme_am | input | 6 | Address modifier |
| vme_addr | input | 32 | Address lines |
| vme_d_in | input | 32 | Data lines, input side |
| vme_d_out | output | 32 | Data lines, output side |
| vme_d_oe | output | 1 | Data driver enable |
| vme_dtack_n | output | 1 | Data acknowledge, active low |
| vme_dtack_oe | output | 1 | DTACK driver enable |
| vme_berr_n | output | 1 | Bus error, active low |
| vme_ga_n | input | 5 | Geographic address pins, active low |
| vme_gap_n | input | 1 | Geographic parity pin |
| bus_addr | output | 32 | Internal bus address |
| bus_wdata | output | 32 | Internal bus write data |
| bus_rdata | input | 32 | Internal bus read data, valid the cycle after bus_rd |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_wr | output | 1 | One-cycle write strobe |
| led_rw | output | 1 | Stretched write activity |
| led_access | output | 1 | Stretched access activity |

## Verification
The hardest state to reach is the boundary-crossing beat of a block transfer. It needs a valid slot, a block modifier, a start address near the top of a 256-byte block, and several complete strobe handshakes before the failing beat. The bench starts a read block transfer at offset 0xF8 of slot 17. The first two beats must be acknowledged at 0xF8 and 0xFC, and the third must draw BERR with no strobe. Invalid-slot cases are reached by setting the geographic pins between cycles, with a parity pin chosen right or deliberately wrong.

// File: rtl/vsb_pkg.sv
package vsb_pkg;

  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int SLOT_W  = 5;
  localparam int WIN_W   = 16;

  typedef enum logic [1:0] {
    AM_SINGLE,
    AM_BLOCK,
    AM_WIDE,
    AM_OTHER
  } am_class_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ACCESS,
    ST_RDWAIT,
    ST_ACK,
    ST_REL,
    ST_BLT_WAIT,
    ST_BERR,
    ST_WAIT_AS
  } state_e;

  function automatic am_class_e am_classify(input logic [5:0] am);
    case (am)
      6'h09, 6'h0D: am_classify = AM_SINGLE;
      6'h0B, 6'h0F: am_classify = AM_BLOCK;
      6'h08, 6'h0C: am_classify = AM_WIDE;
      default:      am_classify = AM_OTHER;
    endcase
  endfunction

  // six raw pin levels must hold an odd number of ones
  function automatic logic ga_parity_ok(input logic [SLOT_W-1:0] ga_n, input logic gap_n);
    ga_parity_ok = ^{ga_n, gap_n};
  endfunction

  function automatic logic [ADDR_W-1:0] slot_base(input logic [SLOT_W-1:0] slot);
    slot_base = {{(ADDR_W-WIN_W-SLOT_W){1'b0}}, slot, {WIN_W{1'b0}}};
  endfunction

  function automatic logic in_window(input logic [ADDR_W-1:0] a, input logic [SLOT_W-1:0] slot);
    in_window = (a[ADDR_W-1:WIN_W] == slot_base(slot) >> WIN_W);
  endfunction

  function automatic logic beat_fault(input logic [ADDR_W-1:0] a, input logic lword_n,
                                      input logic [1:0] ds);
    beat_fault = (a[1:0] != 2'b00) || lword_n || (ds != 2'b11);
  endfunction

  function automatic logic [ADDR_W-1:0] next_beat(input logic [ADDR_W-1:0] a);
    next_beat = a + ADDR_W'(4);
  endfunction

  function automatic logic blt_crosses(input logic [ADDR_W-1:0] a);
    blt_crosses = (next_beat(a) >> 8) != (a >> 8);
  endfunction

endpackage

// File: rtl/vsb_sync.sv
module vsb_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/vsb_geo.sv
module vsb_geo
  import vsb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] ga_n,
  input  logic              gap_n,
  output logic [SLOT_W-1:0] slot,
  output logic              geo_ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot   <= '0;
      geo_ok <= 1'b0;
    end else begin
      slot   <= ~ga_n;
      geo_ok <= ga_parity_ok(ga_n, gap_n) && ((~ga_n) > SLOT_W'(1));
    end
  end
endmodule

// File: rtl/vsb_stretch.sv
module vsb_stretch #(
  parameter int HOLD = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  output logic lit
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (pulse)      cnt <= CW'(HOLD);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end
  assign lit = (cnt != '0);
endmodule

// File: rtl/vme_slave_bridge.sv
module vme_slave_bridge
  import vsb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LED_HOLD = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vme_as_n,
  input  logic [1:0]        vme_ds_n,
  input  logic              vme_write_n,
  input  logic              vme_lword_n,
  input  logic [5:0]        vme_am,
  input  logic [ADDR_W-1:0] vme_addr,
  input  logic [DATA_W-1:0] vme_d_in,
  output logic [DATA_W-1:0] vme_d_out,
  output logic              vme_d_oe,
  output logic              vme_dtack_n,
  output logic              vme_dtack_oe,
  output logic              vme_berr_n,
  input  logic [SLOT_W-1:0] vme_ga_n,
  input  logic              vme_gap_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic              led_rw,
  output logic              led_access
);

  // synchronized strobes, active high after inversion
  logic [2:0] strobe_q;
  vsb_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({vme_as_n, vme_ds_n}), .q(strobe_q)
  );
  logic       as_s;
  logic [1:0] ds_s;
  logic       ds_any_s;
  assign as_s     = ~strobe_q[2];
  assign ds_s     = ~strobe_q[1:0];
  assign ds_any_s = |ds_s;

  logic [SLOT_W-1:0] slot;
  logic              geo_ok;
  vsb_geo i_geo (
    .clk(clk), .rst_n(rst_n), .ga_n(vme_ga_n), .gap_n(vme_gap_n),
    .slot(slot), .geo_ok(geo_ok)
  );

  state_e            state;
  am_class_e         class_q;
  logic              wr_q;
  logic              lword_q;
  logic [1:0]        ds_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  // decision for the first beat, visible to the checker
  logic is_a32, hit, first_fault, blt_fault;
  assign is_a32      = (class_q != AM_OTHER);
  assign hit         = in_window(cur_addr, slot);
  assign first_fault = !geo_ok || (class_q == AM_WIDE) || beat_fault(cur_addr, lword_q, ds_q);
  assign blt_fault   = blt_crosses(cur_addr) || (ds_s != 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      class_q  <= AM_OTHER;
      wr_q     <= 1'b0;
      lword_q  <= 1'b1;
      ds_q     <= 2'b00;
      cur_addr <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (as_s && ds_any_s) begin
          cur_addr <= vme_addr;
          class_q  <= am_classify(vme_am);
          wr_q     <= ~vme_write_n;
          lword_q  <= vme_lword_n;
          ds_q     <= ds_s;
          wdata_q  <= vme_d_in;
          state    <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!is_a32)                 state <= ST_WAIT_AS;
          else if (!geo_ok)            state <= ST_BERR;
          else if (!hit)               state <= ST_WAIT_AS;
          else if (first_fault)        state <= ST_BERR;
          else                         state <= ST_ACCESS;
        end
        ST_ACCESS: state <= wr_q ? ST_ACK : ST_RDWAIT;
        ST_RDWAIT: begin
          rdata_q <= bus_rdata;
          state   <= ST_ACK;
        end
        ST_ACK: if (!ds_any_s) state <= ST_REL;
        ST_REL: begin
          if (!as_s)                    state <= ST_IDLE;
          else if (class_q == AM_BLOCK) state <= ST_BLT_WAIT;
          else                          state <= ST_WAIT_AS;
        end
        ST_BLT_WAIT: begin
          if (!as_s) state <= ST_IDLE;
          else if (ds_any_s) begin
            wdata_q <= vme_d_in;
            if (blt_fault) state <= ST_BERR;
            else begin
              cur_addr <= next_beat(cur_addr);
              state    <= ST_ACCESS;
            end
          end
        end
        ST_BERR:    if (!ds_any_s) state <= ST_WAIT_AS;
        ST_WAIT_AS: if (!as_s) state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assign bus_addr     = cur_addr;
  assign bus_wdata    = wdata_q;
  assign bus_rd       = (state == ST_ACCESS) && !wr_q;
  assign bus_wr       = (state == ST_ACCESS) && wr_q;
  assign vme_d_out    = rdata_q;
  assign vme_d_oe     = (state == ST_ACK) && !wr_q;
  assign vme_dtack_n  = !(state == ST_ACK);
  assign vme_dtack_oe = (state == ST_ACK) || (state == ST_REL);
  assign vme_berr_n   = !(state == ST_BERR);

  vsb_stretch #(.HOLD(LED_HOLD)) i_led_rw (
    .clk(clk), .rst_n(rst_n), .pulse(bus_wr), .lit(led_rw)
  );
  vsb_stretch #(.HOLD(LED_HOLD)) i_led_acc (
    .clk(clk), .rst_n(rst_n), .pulse(bus_rd || bus_wr), .lit(led_access)
  );

endmodule

// File: rtl/vsb_checker.sv
module vsb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        vme_dtack_n,
  input logic        vme_dtack_oe,
  input logic        vme_berr_n,
  input logic        vme_d_oe,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [31:0] bus_addr,
  input logic [4:0]  vme_ga_n,
  input logic        led_rw,
  input logic        ds_any_s,
  input logic        geo_ok
);
  p_ack_berr_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!vme_dtack_n && !vme_berr_n));
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd, bus_wr}));
  p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> (bus_addr[31:16] == {11'd0, ~vme_ga_n}));
  p_dout_with_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vme_d_oe |-> !vme_dtack_n);
  p_no_strobe_bad_geo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> geo_ok);
  p_no_strobe_in_berr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !vme_berr_n |-> !(bus_rd || bus_wr));
  p_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> (bus_addr[1:0] == 2'b00));
  p_dtack_driven_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !vme_dtack_n |-> vme_dtack_oe);
  p_dtack_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vme_dtack_n) |-> !$past(ds_any_s));
  p_led_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> led_rw);
endmodule

bind vme_slave_bridge vsb_checker i_vsb_checker (
  .clk(clk), .rst_n(rst_n), .vme_dtack_n(vme_dtack_n), .vme_dtack_oe(vme_dtack_oe),
  .vme_berr_n(vme_berr_n), .vme_d_oe(vme_d_oe), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .vme_ga_n(vme_ga_n), .led_rw(led_rw), .ds_any_s(ds_any_s),
  .geo_ok(geo_ok)
);

// File: tb/test_vme_slave_bridge.sv
`timescale 1ns/1ps
module test_vme_slave_bridge;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vme_as_n = 1'b1;
  logic [1:0] vme_ds_n = 2'b11;
  logic vme_write_n = 1'b1;
  logic vme_lword_n = 1'b0;
  logic [5:0] vme_am = 6'h09;
  logic [31:0] vme_addr = '0;
  logic [31:0] vme_d_in = '0;
  logic [31:0] vme_d_out;
  logic vme_d_oe, vme_dtack_n, vme_dtack_oe, vme_berr_n;
  logic [4:0] vme_ga_n = 5'b11111;
  logic vme_gap_n = 1'b1;
  logic [31:0] bus_addr, bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic bus_rd, bus_wr, led_rw, led_access;

  always #2.5 clk = ~clk;

  vme_slave_bridge #(.SYNC_STAGES(2), .LED_HOLD(HOLD)) i_vme_slave_bridge (
    .clk(clk), .rst_n(rst_n), .vme_as_n(vme_as_n), .vme_ds_n(vme_ds_n),
    .vme_write_n(vme_write_n), .vme_lword_n(vme_lword_n), .vme_am(vme_am),
    .vme_addr(vme_addr), .vme_d_in(vme_d_in), .vme_d_out(vme_d_out), .vme_d_oe(vme_d_oe),
    .vme_dtack_n(vme_dtack_n), .vme_dtack_oe(vme_dtack_oe), .vme_berr_n(vme_berr_n),
    .vme_ga_n(vme_ga_n), .vme_gap_n(vme_gap_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rd(bus_rd), .bus_wr(bus_wr), .led_rw(led_rw),
    .led_access(led_access)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bus monitor and memory model
  int          nlog = 0;
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  logic        log_wr   [64];
  int          led_acc_cnt = 0;
  int          led_rw_cnt = 0;
  int          oe_bad = 0;

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return a ^ 32'hA5A5_5A5A;
  endfunction

  always @(negedge clk) begin
    if (bus_rd || bus_wr) begin
      log_addr[nlog % 64] <= bus_addr;
      log_data[nlog % 64] <= bus_wr ? bus_wdata : 32'h0;
      log_wr[nlog % 64]   <= bus_wr;
      nlog <= nlog + 1;
    end
    if (bus_rd) bus_rdata <= mem_val(bus_addr);
    if (led_access) led_acc_cnt <= led_acc_cnt + 1;
    if (led_rw) led_rw_cnt <= led_rw_cnt + 1;
    if (!vme_dtack_n && !vme_dtack_oe) oe_bad <= oe_bad + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_slot(input logic [4:0] slot, input bit good_par);
    @(negedge clk);
    vme_ga_n  = ~slot;
    vme_gap_n = good_par ? ~(^(~slot)) : (^(~slot));
    repeat (3) @(negedge clk);
  endtask

  // result: 0 none, 1 ack, 2 berr
  int          res;
  logic [31:0] rd_val;
  bit          oe_seen;
  int          rel_oe_cnt;

  task automatic wait_resp();
    res = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!vme_dtack_n) begin res = 1; rd_val = vme_d_out; oe_seen = vme_d_oe; break; end
      if (!vme_berr_n) begin res = 2; break; end
    end
  endtask

  task automatic release_ds();
    int held;
    held = 0;
    @(negedge clk);
    // keep strobes asserted a few cycles; response must hold (R11)
    for (int i = 0; i < 4; i++) begin
      if (res == 1 && vme_dtack_n) held++;
      @(negedge clk);
    end
    if (res == 1) chk(held == 0, "R11 dtack held while ds low", held, 0);
    vme_ds_n = 2'b11;
    rel_oe_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (vme_dtack_n && vme_dtack_oe) rel_oe_cnt++;
      if (vme_dtack_n && vme_berr_n && i > 4) break;
    end
  endtask

  task automatic vme_single(input logic [5:0] am, input logic [31:0] addr, input bit wr,
                            input logic [31:0] data, input logic [1:0] ds, input logic lw);
    @(negedge clk);
    vme_am = am; vme_addr = addr; vme_write_n = !wr; vme_d_in = data; vme_lword_n = lw;
    @(negedge clk);
    vme_as_n = 1'b0;
    @(negedge clk);
    vme_ds_n = ds;
    wait_resp();
    release_ds();
    vme_as_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(vme_dtack_n === 1'b1 && vme_berr_n === 1'b1, "R1 dtack/berr idle", {vme_dtack_n, vme_berr_n}, 2'b11);
    chk(vme_dtack_oe === 1'b0 && vme_d_oe === 1'b0, "R1 drivers off", {vme_dtack_oe, vme_d_oe}, 0);
    chk(bus_rd === 1'b0 && bus_wr === 1'b0, "R1 no strobe", {bus_rd, bus_wr}, 0);
  endtask

  task automatic t_write_slot17();
    int n0;
    set_slot(5'd17, 1);
    n0 = nlog;
    vme_single(6'h09, 32'h0011_0008, 1, 32'hDEAD_BEEF, 2'b00, 1'b0);
    chk(res == 1, "R2 write ack", res, 1);
    chk(nlog - n0 == 1, "R2 one strobe", nlog - n0, 1);
    chk(log_wr[n0 % 64] == 1 && log_addr[n0 % 64] == 32'h0011_0008, "R2 write addr", log_addr[n0 % 64], 32'h0011_0008);
    chk(log_data[n0 % 64] == 32'hDEAD_BEEF, "R2 write data", log_data[n0 % 64], 32'hDEAD_BEEF);
    chk(rel_oe_cnt == 1, "R11 dtack driven high one cycle", rel_oe_cnt, 1);
    chk(oe_bad == 0, "R11 dtack low without driver", oe_bad, 0);
    n0 = nlog;
    vme_single(6'h0D, 32'h0011_FFFC, 1, 32'h1234_5678, 2'b00, 1'b0);
    chk(res == 1 && nlog - n0 == 1, "R7 supervisory single write", res, 1);
  endtask

  task automatic t_read_slot18();
    int n0;
    set_slot(5'd18, 1);
    n0 = nlog;
    vme_single(6'h09, 32'h0012_0004, 0, 0, 2'b00, 1'b0);
    chk(res == 1, "R3 read ack", res, 1);
    chk(rd_val == mem_val(32'h0012_0004), "R3 read data", rd_val, mem_val(32'h0012_0004));
    chk(oe_seen == 1, "R3 data driver on", oe_seen, 1);
    chk(nlog - n0 == 1 && !log_wr[n0 % 64], "R3 one read strobe", nlog - n0, 1);
    n0 = nlog;
    vme_single(6'h09, 32'h0011_0004, 0, 0, 2'b00, 1'b0);
    chk(res == 0 && nlog == n0, "R8 other window ignored", res, 0);
    set_slot(5'd17, 1);
  endtask

  task automatic t_bad_geo();
    int n0;
    n0 = nlog;
    set_slot(5'd1, 1);
    vme_single(6'h09, 32'h0001_0000, 0, 0, 2'b00, 1'b0);
    chk(res == 2 && nlog == n0, "R4 slot 1 berr", res, 2);
    set_slot(5'd0, 1);
    vme_single(6'h0B, 32'h0000_0000, 1, 5, 2'b00, 1'b0);
    chk(res == 2 && nlog == n0, "R4 slot 0 berr", res, 2);
    set_slot(5'd5, 0);
    vme_single(6'h09, 32'h0005_0000, 1, 7, 2'b00, 1'b0);
    chk(res == 2 && nlog == n0, "R5 parity failure berr", res, 2);
    set_slot(5'd5, 1);
    vme_single(6'h09, 32'h0005_0000, 1, 7, 2'b00, 1'b0);
    chk(res == 1 && nlog == n0 + 1, "R5 good parity served", res, 1);
    set_slot(5'd17, 1);
  endtask

  task automatic t_width_am();
    int n0;
    n0 = nlog;
    vme_single(6'h09, 32'h0011_0002, 1, 1, 2'b00, 1'b0);
    chk(res == 2, "R6 misaligned berr", res, 2);
    vme_single(6'h09, 32'h0011_0010, 1, 1, 2'b00, 1'b1);
    chk(res == 2, "R6 lword high berr", res, 2);
    vme_single(6'h09, 32'h0011_0010, 0, 0, 2'b10, 1'b0);
    chk(res == 2, "R6 single ds berr", res, 2);
    vme_single(6'h08, 32'h0011_0010, 0, 0, 2'b00, 1'b0);
    chk(res == 2, "R7 64-bit block berr", res, 2);
    vme_single(6'h39, 32'h0011_0010, 0, 0, 2'b00, 1'b0);
    chk(res == 0, "R7 foreign modifier ignored", res, 0);
    chk(nlog == n0, "R6 no strobes on faults", nlog - n0, 0);
  endtask

  task automatic vme_block(input logic [31:0] start, input int beats, output int acks, output int last_res);
    acks = 0;
    last_res = 0;
    @(negedge clk);
    vme_am = 6'h0B; vme_addr = start; vme_write_n = 1'b1; vme_lword_n = 1'b0;
    @(negedge clk);
    vme_as_n = 1'b0;
    for (int b = 0; b < beats; b++) begin
      @(negedge clk);
      vme_ds_n = 2'b00;
      wait_resp();
      last_res = res;
      if (res == 1) begin
        chk(rd_val == mem_val(start + 32'(4 * b)), "R9 block read data", rd_val, mem_val(start + 32'(4 * b)));
        acks++;
      end
      release_ds();
      if (res != 1) break;
    end
    vme_as_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_block();
    int n0, acks, lr;
    n0 = nlog;
    vme_block(32'h0011_0020, 3, acks, lr);
    chk(acks == 3 && nlog - n0 == 3, "R9 three beats", acks, 3);
    chk(log_addr[(n0 + 2) % 64] == 32'h0011_0028, "R9 third address", log_addr[(n0 + 2) % 64], 32'h0011_0028);
    n0 = nlog;
    vme_block(32'h0011_00F8, 3, acks, lr);
    chk(acks == 2 && lr == 2, "R10 boundary berr", lr, 2);
    chk(nlog - n0 == 2 && log_addr[(n0 + 1) % 64] == 32'h0011_00FC, "R10 no strobe at 0x100", nlog - n0, 2);
  endtask

  task automatic t_led();
    int a0, w0;
    repeat (20) @(negedge clk);
    a0 = led_acc_cnt; w0 = led_rw_cnt;
    vme_single(6'h09, 32'h0011_0040, 0, 0, 2'b00, 1'b0);
    repeat (20) @(negedge clk);
    chk(led_acc_cnt - a0 == HOLD, "R12 access led length", led_acc_cnt - a0, HOLD);
    chk(led_rw_cnt - w0 == 0, "R12 rw led quiet on read", led_rw_cnt - w0, 0);
    a0 = led_acc_cnt; w0 = led_rw_cnt;
    vme_single(6'h09, 32'h0011_0044, 1, 9, 2'b00, 1'b0);
    repeat (20) @(negedge clk);
    chk(led_rw_cnt - w0 == HOLD && led_acc_cnt - a0 == HOLD, "R12 rw led on write", led_rw_cnt - w0, HOLD);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write_slot17();
    t_read_slot18();
    t_bad_geo();
    t_width_am();
    t_block();
    t_led();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule